// File: doc/BRIEF.md
# PWM duty cycle ramp limiter

This block sits between an automatic fan control loop and a PWM output pin. The control loop supplies an 8-bit target duty cycle that may change at any moment. The block keeps its own internal duty value and slews it toward the target by one count per ramp step. A 3-bit rate code sets the step interval in milliseconds, and a parameter converts milliseconds into clock cycles.

A PWM stage takes a copy of the internal duty value once per PWM period, at the period boundary, and drives the pin from that copy. If the period is shorter than a step, the pin duty stays flat for several periods. If the period is longer than a step, the steps taken during one period show up as a single jump of several counts.

Two cases bypass the slew. A target that rises from zero loads straight into the internal duty. A target that falls to zero either clears the duty at once or ramps it down to zero, depending on a soft-off enable.

Top module: `pwm_ramp_limiter`

## Requirements
- R1: Apart from the zero-target special cases, the internal duty `curDuty` changes by exactly one count per ramp step, toward the target.
- R2: Rate codes 0 to 7 select step intervals of 206, 104, 69, 41, 26, 18, 11 and 5 ms, and each ms is `CYC_PER_MS` clock cycles. A step fires when the step timer has counted a full interval. The timer restarts from zero in any cycle in which the rate code differs from its value in the previous cycle.
- R3: The PWM counter advances once every `pwmDiv+1` clocks and counts 0 to 254, so one period is 255*(`pwmDiv+1`) clocks. The pin duty copy takes the value of `curDuty` only when the counter wraps from 254 to 0.
- R4: When a PWM period spans several ramp steps, the pin duty changes by the total number of steps taken in that period, at one boundary.
- R5: The internal duty never passes the target. Once it equals the target, it stays there until the target changes.
- R6: `pwmPin` is high exactly while the PWM counter is below the latched duty. A latched duty of 255 gives a constant high pin, and a latched duty of 0 gives a constant low pin.
- R7: When the target becomes nonzero after being 0 in the previous cycle, `curDuty` equals the target one clock later, with no ramp.
- R8: When the target is 0 and `softOffEn` is 0, `curDuty` is 0 one clock later.
- R9: When the target is 0 and `softOffEn` is 1, `curDuty` ramps down to 0 at the programmed rate.
- R10: After reset, the internal duty, the latched duty, the PWM counter and the step timer are all 0, and `pwmPin` is low.
- R11: A change of target while ramping takes effect at the next step. The ramp then moves toward the newest target, and it reverses direction if needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| targetDuty | input | 8 | Target duty from the fan control loop, 255 = full on |
| rateSel | input | 3 | Ramp step interval code |
| softOffEn | input | 1 | 1: ramp down to zero on a zero target; 0: stop at once |
| pwmDiv | input | DIV_W | PWM counter prescale, counter advances every pwmDiv+1 clocks |
| curDuty | output | 8 | Current internal duty value |
| pwmPin | output | 1 | PWM output |

## Verification
The bench compares both outputs every cycle against a model of the requirements.

It measures the exact gap between two steps, so a timer that is off by one shows up as a wrong gap. It also drives a long PWM period with short steps. A design that latches the pin duty outside the boundary, or clamps the jump wrongly, then shows wrong pin widths or an overshoot.

Directed cases cover the wake-up jump, the hard stop and the soft stop. A design that mixes these up ramps where it should jump, or jumps where it should ramp. Random targets that hit zero often, with random rates and periods, exercise reversals mid-ramp and the restart of the step timer on a rate change.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;

  typedef struct packed {
    logic load;     // take the target directly
    logic clear;    // force duty to zero
    logic up;       // one count up
    logic down;     // one count down
    logic pwmTick;  // advance the PWM counter
  } rampCtl_t;

  function automatic int unsigned stepMs(input logic [2:0] code);
    case (code)
      3'd0:    stepMs = 206;
      3'd1:    stepMs = 104;
      3'd2:    stepMs = 69;
      3'd3:    stepMs = 41;
      3'd4:    stepMs = 26;
      3'd5:    stepMs = 18;
      3'd6:    stepMs = 11;
      default: stepMs = 5;
    endcase
  endfunction

endpackage

// File: rtl/pwm_ramp_ctrl.sv
module pwm_ramp_ctrl
  import pwm_ramp_pkg::*;
#(
  parameter int CYC_PER_MS = 1000,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       targetDuty,
  input  logic [2:0]       rateSel,
  input  logic             softOffEn,
  input  logic [DIV_W-1:0] pwmDiv,
  input  logic [7:0]       rampDuty,
  output rampCtl_t         ctl
);

  localparam int MAX_CYC = 206 * CYC_PER_MS;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] stepLimit;
  logic [2:0]       prevRate;
  logic [7:0]       prevTarget;
  logic [DIV_W-1:0] divCnt;
  logic             rateChg;
  logic             stepHit;

  assign stepLimit = CNT_W'(stepMs(rateSel) * CYC_PER_MS - 1);
  assign rateChg   = (rateSel != prevRate);
  assign stepHit   = !rateChg && (stepCnt == stepLimit);

  always_comb begin
    ctl         = '0;
    ctl.pwmTick = (divCnt >= pwmDiv);
    ctl.clear   = (targetDuty == 8'd0) && !softOffEn;
    ctl.load    = !ctl.clear && (prevTarget == 8'd0) && (targetDuty != 8'd0);
    ctl.up      = !ctl.clear && !ctl.load && stepHit && (rampDuty < targetDuty);
    ctl.down    = !ctl.clear && !ctl.load && stepHit && (rampDuty > targetDuty);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepCnt    <= '0;
      prevRate   <= '0;
      prevTarget <= '0;
      divCnt     <= '0;
    end else begin
      prevRate   <= rateSel;
      prevTarget <= targetDuty;
      stepCnt    <= (rateChg || stepHit) ? '0 : stepCnt + 1'b1;
      divCnt     <= ctl.pwmTick ? '0 : divCnt + 1'b1;
    end
  end

  AST_HARD_OFF: assert property (@(posedge clk) disable iff (rst)
    (targetDuty == 8'd0 && !softOffEn) |=> (rampDuty == 8'd0)); // R8

  AST_WAKE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (prevTarget == 8'd0 && targetDuty != 8'd0) |=> (rampDuty == $past(targetDuty))); // R7

  AST_STEP_GAP: assert property (@(posedge clk) disable iff (rst)
    (ctl.up || ctl.down) |=> !(ctl.up || ctl.down)); // R2

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.load, ctl.clear, ctl.up, ctl.down})); // R1

endmodule

// File: rtl/pwm_ramp_dp.sv
module pwm_ramp_dp
  import pwm_ramp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] targetDuty,
  input  rampCtl_t   ctl,
  output logic [7:0] rampDuty,
  output logic       pwmPin
);

  localparam logic [7:0] PWM_LAST = 8'd254;

  logic [7:0] pwmCnt;
  logic [7:0] latchedDuty;
  logic       boundary;

  assign boundary = ctl.pwmTick && (pwmCnt == PWM_LAST);
  assign pwmPin   = (pwmCnt < latchedDuty);

  always_ff @(posedge clk) begin
    if (rst) begin
      rampDuty    <= '0;
      pwmCnt      <= '0;
      latchedDuty <= '0;
    end else begin
      if (ctl.clear)     rampDuty <= '0;
      else if (ctl.load) rampDuty <= targetDuty;
      else if (ctl.up)   rampDuty <= rampDuty + 8'd1;
      else if (ctl.down) rampDuty <= rampDuty - 8'd1;

      if (ctl.pwmTick) pwmCnt <= boundary ? 8'd0 : pwmCnt + 8'd1;
      if (boundary)    latchedDuty <= rampDuty;
    end
  end

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    !(ctl.load || ctl.clear) |=>
      (rampDuty == $past(rampDuty) || rampDuty == $past(rampDuty) + 8'd1 ||
       rampDuty == $past(rampDuty) - 8'd1)); // R1

  AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (rst)
    ctl.up |=> (rampDuty <= $past(targetDuty))); // R5

  AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (rst)
    ctl.down |=> (rampDuty >= $past(targetDuty))); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(latchedDuty)); // R3

  AST_PIN_FULL: assert property (@(posedge clk) disable iff (rst)
    (latchedDuty == 8'd255) |-> pwmPin); // R6

  AST_PIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (latchedDuty == 8'd0) |-> !pwmPin); // R6

endmodule

// File: rtl/pwm_ramp_limiter.sv
module pwm_ramp_limiter
  import pwm_ramp_pkg::*;
#(
  parameter int CYC_PER_MS = 1000,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       targetDuty,
  input  logic [2:0]       rateSel,
  input  logic             softOffEn,
  input  logic [DIV_W-1:0] pwmDiv,
  output logic [7:0]       curDuty,
  output logic             pwmPin
);

  rampCtl_t ctl;

  pwm_ramp_ctrl #(
    .CYC_PER_MS(CYC_PER_MS),
    .DIV_W     (DIV_W)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .targetDuty(targetDuty),
    .rateSel   (rateSel),
    .softOffEn (softOffEn),
    .pwmDiv    (pwmDiv),
    .rampDuty  (curDuty),
    .ctl       (ctl)
  );

  pwm_ramp_dp dp_i (
    .clk       (clk),
    .rst       (rst),
    .targetDuty(targetDuty),
    .ctl       (ctl),
    .rampDuty  (curDuty),
    .pwmPin    (pwmPin)
  );

  AST_RESET_LOW: assert property (@(posedge clk) rst |=> (curDuty == 8'd0 && !pwmPin)); // R10

endmodule

// File: tb/pwm_ramp_limiter_tb_top.sv
`timescale 1ns/1ps
module pwm_ramp_limiter_tb_top;

  localparam int CPM   = 2;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       targetDuty = 8'd0;
  logic [2:0]       rateSel = 3'd0;
  logic             softOffEn = 1'b0;
  logic [DIV_W-1:0] pwmDiv = '0;
  logic [7:0]       curDuty;
  logic             pwmPin;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string phaseTag = "R1";

  always #2 clk = ~clk;

  pwm_ramp_limiter #(.CYC_PER_MS(CPM), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .targetDuty(targetDuty), .rateSel(rateSel),
    .softOffEn(softOffEn), .pwmDiv(pwmDiv), .curDuty(curDuty), .pwmPin(pwmPin)
  );

  function automatic int intervalCyc(input logic [2:0] code);
    int ms [8] = '{206, 104, 69, 41, 26, 18, 11, 5};
    return ms[code] * CPM;
  endfunction

  // reference model built from the requirements
  int mRamp, mPrevT, mPrevR, mTimer, mDiv, mCnt, mLatch;
  always @(posedge clk) begin
    if (rst) begin
      mRamp = 0; mPrevT = 0; mPrevR = 0; mTimer = 0; mDiv = 0; mCnt = 0; mLatch = 0;
    end else begin
      bit step, tick;
      step = (int'(rateSel) == mPrevR) && (mTimer == intervalCyc(rateSel) - 1);
      mTimer = (step || int'(rateSel) != mPrevR) ? 0 : mTimer + 1;
      tick = (mDiv >= int'(pwmDiv));
      mDiv = tick ? 0 : mDiv + 1;
      if (tick) begin
        if (mCnt == 254) begin mCnt = 0; mLatch = mRamp; end
        else mCnt = mCnt + 1;
      end
      if (targetDuty == 0 && !softOffEn) mRamp = 0;
      else if (mPrevT == 0 && targetDuty != 0) mRamp = int'(targetDuty);
      else if (step && mRamp < int'(targetDuty)) mRamp = mRamp + 1;
      else if (step && mRamp > int'(targetDuty)) mRamp = mRamp - 1;
      mPrevT = int'(targetDuty);
      mPrevR = int'(rateSel);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(phaseTag, int'(curDuty), mRamp);
      chk("R3/R6 pin", int'(pwmPin), int'(mCnt < mLatch));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int prev, gap, highs;
    void'($urandom(32'h5EED_1234));
    waitCyc(3);
    chk("R10 duty", int'(curDuty), 0);
    chk("R10 pin", int'(pwmPin), 0);
    rst = 1'b0;
    waitCyc(2);
    chk("R10 after release", int'(curDuty), 0);

    // wake-up jump
    phaseTag = "R7"; rateSel = 3'd5; targetDuty = 8'd100;
    waitCyc(1);
    chk("R7 jump", int'(curDuty), 100);

    // step interval
    phaseTag = "R2"; targetDuty = 8'd140;
    prev = curDuty;
    while (int'(curDuty) == prev) waitCyc(1);
    prev = curDuty; gap = 0;
    while (int'(curDuty) == prev) begin waitCyc(1); gap++; end
    chk("R2 step gap", gap, intervalCyc(3'd5));
    chk("R1 step size", int'(curDuty) - prev, 1);

    // reversal mid-ramp, then settle
    phaseTag = "R11"; targetDuty = 8'd100;
    waitCyc(40 * intervalCyc(3'd5));
    chk("R5 settled", int'(curDuty), 100);
    phaseTag = "R5"; rateSel = 3'd7; targetDuty = 8'd255;
    waitCyc(170 * intervalCyc(3'd7));
    chk("R5 full", int'(curDuty), 255);
    waitCyc(600);
    highs = 0;
    for (int i = 0; i < 300; i++) begin highs += int'(pwmPin); waitCyc(1); end
    chk("R6 constant high", highs, 300);

    // hard stop
    phaseTag = "R8"; targetDuty = 8'd0; softOffEn = 1'b0;
    waitCyc(1);
    chk("R8 hard off", int'(curDuty), 0);
    waitCyc(600);
    highs = 0;
    for (int i = 0; i < 300; i++) begin highs += int'(pwmPin); waitCyc(1); end
    chk("R6 constant low", highs, 0);

    // soft stop
    phaseTag = "R9"; targetDuty = 8'd30;
    waitCyc(5);
    softOffEn = 1'b1; targetDuty = 8'd0;
    waitCyc(2);
    chk("R9 not instant", int'(curDuty), 30);
    waitCyc(32 * intervalCyc(3'd7));
    chk("R9 ramped to zero", int'(curDuty), 0);

    // long period: several steps per period
    phaseTag = "R4"; softOffEn = 1'b0; pwmDiv = 16'd20; targetDuty = 8'd10;
    waitCyc(3);
    targetDuty = 8'd200;
    waitCyc(4 * 255 * 21);
    chk("R4 final", int'(curDuty), 200);

    // random mix
    phaseTag = "R1";
    for (int it = 0; it < 40; it++) begin
      targetDuty = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 255));
      rateSel    = 3'($urandom_range(5, 7));
      softOffEn  = 1'($urandom_range(0, 1));
      pwmDiv     = DIV_W'($urandom_range(0, 3));
      waitCyc($urandom_range(50, 1500));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule